// File: doc/BRIEF.md
# 64-bit Integer and Bitwise Execution Unit

This block is the execution stage for the integer-arithmetic and bitwise operation groups of a small 64-bit register machine. For each operation it takes a group select, a 4-bit variant code, an 8-bit bit index, the current value of the destination register and two 64-bit source operands. It returns the 64-bit value to be written back to the destination register. That value is registered, so it appears one clock after the operands are presented.

Arithmetic covers add, subtract, multiply, unsigned divide and remainder, and negate. The flag variants do not write a status register. They write the carry, the borrow or the multiply overflow into one chosen bit of the destination value, and the other destination bits pass through unchanged. The bitwise group covers the three shifts, the two rotates, copy, not and the six two-input logic functions.

Top module: `alu64_exec`

## Requirements
- R1: While `rst` is high at a rising clock edge, `result` becomes 0 after that edge. Otherwise `result` takes, after each rising edge, the value computed from the inputs sampled at that edge.
- R2: With `grp_sel`=0 (integer group), variant 0 gives `src_a`+`src_b`, variant 2 gives `src_a`-`src_b` and variant 8 gives -`src_a`, all modulo 2^64.
- R3: In the integer group, variant 1 and variant 3 write a flag into bit `bit_idx[5:0]` of `dest_in`: the unsigned carry out of `src_a`+`src_b` for variant 1, and the borrow of `src_a`-`src_b` (1 when `src_a` < `src_b` unsigned) for variant 3. Every other bit keeps its `dest_in` value, and `bit_idx[7:6]` are ignored.
- R4: In the integer group, variant 4 gives the low 64 bits of the unsigned product. Variant 5 writes into bit `bit_idx[5:0]` of `dest_in` a 1 when the upper 64 bits of the 128-bit product are nonzero, and leaves the other bits unchanged.
- R5: In the integer group, variant 6 gives the unsigned quotient and variant 7 the unsigned remainder. A zero divisor gives all ones for the quotient and `src_a` for the remainder.
- R6: With `grp_sel`=1 (bitwise group), variant 0 shifts left, variant 1 shifts right logically and variant 2 shifts right arithmetically. Each shifts `src_a` by `src_b[5:0]`, and the upper bits of `src_b` are ignored.
- R7: In the bitwise group, variant 3 rotates `src_a` left and variant 4 rotates it right, by `src_b[5:0]`.
- R8: In the bitwise group, variant 5 gives `src_a` and variant 6 gives ~`src_a`. `src_b` has no effect on either.
- R9: In the bitwise group, variants 7, 8, 9, A, B and C give `src_a` OR, AND, NAND, NOR, XOR and XNOR `src_b` respectively.
- R10: Integer variants 9 to F and bitwise variants D to F return `dest_in` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| grp_sel | input | 1 | Operation group: 0 integer, 1 bitwise |
| variant | input | 4 | Variant code within the group |
| bit_idx | input | 8 | Destination bit index for flag variants (low 6 bits used) |
| dest_in | input | 64 | Current value of the destination register |
| src_a | input | 64 | First source operand |
| src_b | input | 64 | Second source operand, and the shift or rotate amount |
| result | output | 64 | Registered write-back value |

## Verification
The only state is the output register, so an error in the datapath or the variant decode shows at `result` one clock after the operands are applied. A flag placed in the wrong bit position, or a flag variant that overwrites the destination value, shows as a difference in a bit other than the indexed one. A missing zero-divisor guard, or a shift that uses more than six bits of its amount, shows only at the boundary operands. The bench applies those operands directly.

// File: rtl/alu64_pkg.sv
package alu64_pkg;

  typedef enum logic [3:0] {
    IOP_ADD  = 4'h0,
    IOP_ADDC = 4'h1,
    IOP_SUB  = 4'h2,
    IOP_SUBB = 4'h3,
    IOP_MUL  = 4'h4,
    IOP_MULV = 4'h5,
    IOP_DIV  = 4'h6,
    IOP_REM  = 4'h7,
    IOP_NEG  = 4'h8
  } int_op_e;

  typedef enum logic [3:0] {
    BOP_SHL  = 4'h0,
    BOP_SHR  = 4'h1,
    BOP_SAR  = 4'h2,
    BOP_ROL  = 4'h3,
    BOP_ROR  = 4'h4,
    BOP_COPY = 4'h5,
    BOP_NOT  = 4'h6,
    BOP_OR   = 4'h7,
    BOP_AND  = 4'h8,
    BOP_NAND = 4'h9,
    BOP_NOR  = 4'hA,
    BOP_XOR  = 4'hB,
    BOP_XNOR = 4'hC
  } bit_op_e;

  localparam logic GRP_INT = 1'b0;
  localparam logic GRP_BIT = 1'b1;

endpackage

// File: rtl/alu64_int_unit.sv
module alu64_int_unit #(
  parameter int DATA_W = 64
) (
  input  logic [3:0]                 op,
  input  logic [$clog2(DATA_W)-1:0]  flag_pos,
  input  logic [DATA_W-1:0]          dest,
  input  logic [DATA_W-1:0]          a,
  input  logic [DATA_W-1:0]          b,
  output logic [DATA_W-1:0]          y
);
  import alu64_pkg::*;

  logic [DATA_W:0]     sum_ext;
  logic [2*DATA_W-1:0] prod;
  logic                borrow;
  logic                mul_ovf;
  logic                div_zero;
  logic [DATA_W-1:0]   quot;
  logic [DATA_W-1:0]   remd;
  logic [DATA_W-1:0]   flagged;
  logic                flag;

  assign sum_ext  = {1'b0, a} + {1'b0, b};
  assign prod     = {{DATA_W{1'b0}}, a} * {{DATA_W{1'b0}}, b};
  assign borrow   = (a < b);
  assign mul_ovf  = |prod[2*DATA_W-1:DATA_W];
  assign div_zero = (b == '0);
  assign quot     = div_zero ? {DATA_W{1'b1}} : (a / b);
  assign remd     = div_zero ? a : (a % b);

  always_comb begin
    unique case (op)
      IOP_ADDC: flag = sum_ext[DATA_W];
      IOP_SUBB: flag = borrow;
      default:  flag = mul_ovf;
    endcase
    flagged = dest;
    flagged[flag_pos] = flag;
  end

  always_comb begin
    case (op)
      IOP_ADD:  y = sum_ext[DATA_W-1:0];
      IOP_ADDC: y = flagged;
      IOP_SUB:  y = a - b;
      IOP_SUBB: y = flagged;
      IOP_MUL:  y = prod[DATA_W-1:0];
      IOP_MULV: y = flagged;
      IOP_DIV:  y = quot;
      IOP_REM:  y = remd;
      IOP_NEG:  y = '0 - a;
      default:  y = dest;
    endcase
  end

endmodule

// File: rtl/alu64_bit_unit.sv
module alu64_bit_unit #(
  parameter int DATA_W = 64
) (
  input  logic [3:0]        op,
  input  logic [DATA_W-1:0] dest,
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  output logic [DATA_W-1:0] y
);
  import alu64_pkg::*;

  localparam int SH_W = $clog2(DATA_W);

  logic [SH_W-1:0]   amt;
  logic [DATA_W-1:0] rol_v;
  logic [DATA_W-1:0] ror_v;
  logic [DATA_W-SH_W-1:0] unused_amt_hi;

  assign amt           = b[SH_W-1:0];
  assign unused_amt_hi = b[DATA_W-1:SH_W];

  // Rotates built as one index mux per output bit.
  for (genvar i = 0; i < DATA_W; i++) begin : g_rot
    logic [SH_W-1:0] src_l;
    logic [SH_W-1:0] src_r;
    assign src_l    = SH_W'(i) - amt;
    assign src_r    = SH_W'(i) + amt;
    assign rol_v[i] = a[src_l];
    assign ror_v[i] = a[src_r];
  end

  always_comb begin
    case (op)
      BOP_SHL:  y = a << amt;
      BOP_SHR:  y = a >> amt;
      BOP_SAR:  y = DATA_W'($signed(a) >>> amt);
      BOP_ROL:  y = rol_v;
      BOP_ROR:  y = ror_v;
      BOP_COPY: y = a;
      BOP_NOT:  y = ~a;
      BOP_OR:   y = a | b;
      BOP_AND:  y = a & b;
      BOP_NAND: y = ~(a & b);
      BOP_NOR:  y = ~(a | b);
      BOP_XOR:  y = a ^ b;
      BOP_XNOR: y = ~(a ^ b);
      default:  y = dest;
    endcase
  end

endmodule

// File: rtl/alu64_exec.sv
module alu64_exec #(
  parameter int DATA_W = 64,
  parameter int IDX_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              grp_sel,
  input  logic [3:0]        variant,
  input  logic [IDX_W-1:0]  bit_idx,
  input  logic [DATA_W-1:0] dest_in,
  input  logic [DATA_W-1:0] src_a,
  input  logic [DATA_W-1:0] src_b,
  output logic [DATA_W-1:0] result
);
  import alu64_pkg::*;

  localparam int SH_W = $clog2(DATA_W);

  logic [DATA_W-1:0] int_y;
  logic [DATA_W-1:0] bit_y;
  logic [DATA_W-1:0] next_y;
  logic [IDX_W-SH_W-1:0] unused_idx_hi;

  assign unused_idx_hi = bit_idx[IDX_W-1:SH_W];

  alu64_int_unit #(.DATA_W(DATA_W)) u_int (
    .op       (variant),
    .flag_pos (bit_idx[SH_W-1:0]),
    .dest     (dest_in),
    .a        (src_a),
    .b        (src_b),
    .y        (int_y)
  );

  alu64_bit_unit #(.DATA_W(DATA_W)) u_bit (
    .op   (variant),
    .dest (dest_in),
    .a    (src_a),
    .b    (src_b),
    .y    (bit_y)
  );

  assign next_y = (grp_sel == GRP_BIT) ? bit_y : int_y;

  always_ff @(posedge clk) begin
    if (rst) result <= '0;
    else     result <= next_y;
  end

  // R1: reset clears the output register
  a_r1_reset_clear: assert property (@(posedge clk) rst |=> result == '0);

  // R3 / R4: flag variants touch at most the indexed bit
  a_r3_flag_only_one_bit: assert property (@(posedge clk) disable iff (rst)
    (grp_sel == GRP_INT && (variant == 4'h1 || variant == 4'h3 || variant == 4'h5))
    |=> ((result ^ $past(dest_in)) & ~(DATA_W'(1) << $past(bit_idx[SH_W-1:0]))) == '0);

  // R5: zero divisor yields all ones quotient
  a_r5_div_zero: assert property (@(posedge clk) disable iff (rst)
    (grp_sel == GRP_INT && variant == 4'h6 && src_b == '0) |=> &result);

  // R5: remainder is below a nonzero divisor
  a_r5_rem_bound: assert property (@(posedge clk) disable iff (rst)
    (grp_sel == GRP_INT && variant == 4'h7 && src_b != '0) |=> result < $past(src_b));

  // R8: copy returns the first operand
  a_r8_copy: assert property (@(posedge clk) disable iff (rst)
    (grp_sel == GRP_BIT && variant == 4'h5) |=> result == $past(src_a));

  // R7: rotate preserves the population count
  a_r7_rot_popcount: assert property (@(posedge clk) disable iff (rst)
    (grp_sel == GRP_BIT && (variant == 4'h3 || variant == 4'h4))
    |=> $countones(result) == $countones($past(src_a)));

  // R10: unused codes pass the destination through
  a_r10_unused: assert property (@(posedge clk) disable iff (rst)
    ((grp_sel == GRP_INT && variant > 4'h8) || (grp_sel == GRP_BIT && variant > 4'hC))
    |=> result == $past(dest_in));

endmodule

// File: tb/alu64_exec_test.sv
module alu64_exec_test;

  logic        clk = 1'b0;
  logic        rst;
  logic        grp_sel;
  logic [3:0]  variant;
  logic [7:0]  bit_idx;
  logic [63:0] dest_in;
  logic [63:0] src_a;
  logic [63:0] src_b;
  logic [63:0] result;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  localparam logic [63:0] ONES = 64'hFFFF_FFFF_FFFF_FFFF;

  always #5 clk = ~clk;

  alu64_exec uut (
    .clk(clk), .rst(rst), .grp_sel(grp_sel), .variant(variant),
    .bit_idx(bit_idx), .dest_in(dest_in), .src_a(src_a), .src_b(src_b),
    .result(result)
  );

  task automatic check(input string tag, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  // Drive at a falling edge, let one rising edge capture, sample at the next falling edge.
  task automatic run_op(input logic g, input logic [3:0] v, input logic [7:0] idx,
                        input logic [63:0] d, input logic [63:0] a, input logic [63:0] b);
    grp_sel = g; variant = v; bit_idx = idx; dest_in = d; src_a = a; src_b = b;
    @(negedge clk);
  endtask

  task automatic t_reset();
    rst = 1'b1;
    run_op(1'b1, 4'h6, 8'h0, 64'h0, 64'h0, 64'h0);
    check("R1 reset with not-operands", result, 64'h0);
    rst = 1'b0;
    run_op(1'b0, 4'h0, 8'h0, 64'h0, 64'd3, 64'd4);
    check("R1 first result after reset", result, 64'd7);
    rst = 1'b1;
    run_op(1'b0, 4'h0, 8'h0, 64'h0, 64'd3, 64'd4);
    check("R1 reset clears held result", result, 64'h0);
    rst = 1'b0;
  endtask

  task automatic t_addsub();
    run_op(1'b0, 4'h0, 8'h0, 64'h0, ONES, 64'd2);
    check("R2 add wraps", result, 64'd1);
    run_op(1'b0, 4'h2, 8'h0, 64'h0, 64'd0, 64'd1);
    check("R2 sub wraps", result, ONES);
    run_op(1'b0, 4'h8, 8'h0, 64'h0, 64'd5, 64'd99);
    check("R2 negate", result, 64'hFFFF_FFFF_FFFF_FFFB);
  endtask

  task automatic t_flags();
    run_op(1'b0, 4'h1, 8'd7, 64'h0, ONES, 64'd1);
    check("R3 carry into bit 7", result, 64'h80);
    run_op(1'b0, 4'h1, 8'h47, ONES, 64'd1, 64'd1);
    check("R3 no carry clears bit 7, upper idx bits ignored", result, 64'hFFFF_FFFF_FFFF_FF7F);
    run_op(1'b0, 4'h3, 8'd63, 64'h0, 64'd3, 64'd5);
    check("R3 borrow into bit 63", result, 64'h8000_0000_0000_0000);
    run_op(1'b0, 4'h3, 8'd0, ONES, 64'd5, 64'd3);
    check("R3 no borrow clears bit 0", result, 64'hFFFF_FFFF_FFFF_FFFE);
  endtask

  task automatic t_mul();
    run_op(1'b0, 4'h4, 8'h0, 64'h0, 64'h1_0000_0000, 64'h1_0000_0003);
    check("R4 multiply low half", result, 64'h0000_0003_0000_0000);
    run_op(1'b0, 4'h5, 8'd1, 64'h0, 64'h1_0000_0000, 64'h1_0000_0003);
    check("R4 multiply overflow set", result, 64'h2);
    run_op(1'b0, 4'h5, 8'd0, 64'hF, 64'hFFFF_FFFF, 64'hFFFF_FFFF);
    check("R4 multiply no overflow", result, 64'hE);
  endtask

  task automatic t_div();
    run_op(1'b0, 4'h6, 8'h0, 64'h0, 64'd100, 64'd7);
    check("R5 quotient", result, 64'd14);
    run_op(1'b0, 4'h7, 8'h0, 64'h0, 64'd100, 64'd7);
    check("R5 remainder", result, 64'd2);
    run_op(1'b0, 4'h6, 8'h0, 64'h0, ONES, 64'd2);
    check("R5 unsigned quotient", result, 64'h7FFF_FFFF_FFFF_FFFF);
    run_op(1'b0, 4'h6, 8'h0, 64'h0, 64'd123, 64'd0);
    check("R5 divide by zero", result, ONES);
    run_op(1'b0, 4'h7, 8'h0, 64'h0, 64'd123, 64'd0);
    check("R5 remainder by zero", result, 64'd123);
  endtask

  task automatic t_shift();
    run_op(1'b1, 4'h0, 8'h0, 64'h0, 64'h8000_0000_0000_0001, 64'd4);
    check("R6 shift left", result, 64'h10);
    run_op(1'b1, 4'h1, 8'h0, 64'h0, 64'h8000_0000_0000_0001, 64'd4);
    check("R6 logical right", result, 64'h0800_0000_0000_0000);
    run_op(1'b1, 4'h2, 8'h0, 64'h0, 64'h8000_0000_0000_0001, 64'd4);
    check("R6 arithmetic right", result, 64'hF800_0000_0000_0000);
    run_op(1'b1, 4'h0, 8'h0, 64'h0, 64'h8000_0000_0000_0001, 64'h41);
    check("R6 amount uses low 6 bits", result, 64'h2);
  endtask

  task automatic t_rot();
    run_op(1'b1, 4'h3, 8'h0, 64'h0, 64'h8000_0000_0000_0001, 64'd4);
    check("R7 rotate left", result, 64'h18);
    run_op(1'b1, 4'h4, 8'h0, 64'h0, 64'h8000_0000_0000_0001, 64'd4);
    check("R7 rotate right", result, 64'h1800_0000_0000_0000);
    run_op(1'b1, 4'h3, 8'h0, 64'h0, 64'h1234_5678_9ABC_DEF0, 64'd64);
    check("R7 rotate by 64 is identity", result, 64'h1234_5678_9ABC_DEF0);
  endtask

  task automatic t_unary();
    run_op(1'b1, 4'h5, 8'h0, 64'h55, 64'h1234, ONES);
    check("R8 copy ignores src_b", result, 64'h1234);
    run_op(1'b1, 4'h6, 8'h0, 64'h55, 64'h0, 64'hAAAA);
    check("R8 not ignores src_b", result, ONES);
  endtask

  task automatic t_logic();
    logic [63:0] a = 64'hF0F0;
    logic [63:0] b = 64'hFF00;
    run_op(1'b1, 4'h7, 8'h0, 64'h0, a, b); check("R9 or",   result, 64'hFFF0);
    run_op(1'b1, 4'h8, 8'h0, 64'h0, a, b); check("R9 and",  result, 64'hF000);
    run_op(1'b1, 4'h9, 8'h0, 64'h0, a, b); check("R9 nand", result, 64'hFFFF_FFFF_FFFF_0FFF);
    run_op(1'b1, 4'hA, 8'h0, 64'h0, a, b); check("R9 nor",  result, 64'hFFFF_FFFF_FFFF_000F);
    run_op(1'b1, 4'hB, 8'h0, 64'h0, a, b); check("R9 xor",  result, 64'h0FF0);
    run_op(1'b1, 4'hC, 8'h0, 64'h0, a, b); check("R9 xnor", result, 64'hFFFF_FFFF_FFFF_F00F);
  endtask

  task automatic t_unused();
    run_op(1'b0, 4'h9, 8'h0, 64'hDEAD, 64'd1, 64'd2);
    check("R10 integer code 9", result, 64'hDEAD);
    run_op(1'b0, 4'hF, 8'h0, 64'hBEEF, 64'd1, 64'd2);
    check("R10 integer code F", result, 64'hBEEF);
    run_op(1'b1, 4'hD, 8'h0, 64'hCAFE, 64'd1, 64'd2);
    check("R10 bitwise code D", result, 64'hCAFE);
  endtask

  initial begin
    rst = 1'b1; grp_sel = 1'b0; variant = 4'h0; bit_idx = 8'h0;
    dest_in = '0; src_a = '0; src_b = '0;
    @(negedge clk);
    t_reset();
    t_addsub();
    t_flags();
    t_mul();
    t_div();
    t_shift();
    t_rot();
    t_unary();
    t_logic();
    t_unused();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule